// File: doc/BRIEF.md
# Programmable-Format Serial Character Receiver

This block recovers characters from an asynchronous serial line. A separate rate generator supplies a clock enable at sixteen times the bit rate, and the receiver counts these enables to find the middle of each bit. A falling edge on the idle-high line starts a candidate frame. The receiver keeps the frame only if the line is still low halfway through the start bit. If the line has gone high again by then, the edge is treated as noise and the receiver waits for the next one.

Software-visible format controls set the data length (5 to 8 bits), parity (none, even or odd) and the stop period (one bit, or a longer period). When a character is complete, the receiver presents it with three flags: bad parity, missing stop level, and line break. A one-clock strobe marks the new character. The outputs hold their values until the next character arrives. After a break, the receiver stays quiet until the line has been high again.

Top module: `serial_rx_deframer`

## Requirements
- R1: `len_sel` selects 5, 6, 7 or 8 data bits (00, 01, 10, 11). Bits are taken first bit first into bit 0 of `char_data`, and the bits above the selected length read zero.
- R2: With `par_en`=1, one parity bit follows the data. `par_odd`=0 means even parity and `par_odd`=1 means odd parity. `char_perr` is 1 when the received parity disagrees with that rule. With `par_en`=0 no parity slot exists and `char_perr` is 0.
- R3: `stop_sel`=0 gives one stop bit. `stop_sel`=1 gives two stop bits, except that with 5-bit characters it gives one and a half. `char_ferr` is 1 when any stop-period sample reads low.
- R4: A start bit is accepted only if the line still reads low at the 8th sample enable after the edge was seen. Otherwise no character is produced.
- R5: When every data, parity and stop sample reads low, exactly one character is reported, with `char_brk`=1, `char_ferr`=1 and data zero. The receiver then ignores the line until it returns high.
- R6: `char_valid` is high for exactly one clock per character, the clock after the last stop sample. The data and flags hold until the next strobe.
- R7: A new start bit that immediately follows the stop period of the previous character is received without loss.
- R8: After reset, `char_valid`, `char_data` and all flags are zero and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| sample_tick | input | 1 | Clock enable at 16x the bit rate |
| len_sel | input | 2 | Data length select: 00=5, 01=6, 10=7, 11=8 bits |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| stop_sel | input | 1 | 0 = one stop bit, 1 = two (one and a half for 5-bit characters) |
| char_valid | output | 1 | One-clock strobe for a new character |
| char_data | output | 8 | Received data, zero-extended |
| char_perr | output | 1 | Parity mismatch flag |
| char_ferr | output | 1 | Stop-level missing flag |
| char_brk | output | 1 | Line break flag |

## Verification
The hardest condition to reach is a break. The line must stay low through every data, parity and stop sample and then remain low well past the frame. The stimulus holds the line low for three extra bit times. It then checks that only one break character appeared, and that a normal character sent after the line went high again is received cleanly. The half-bit stop sample in the one-and-a-half setting is also hard to hit. The bench reaches it by driving only the half-length tail of the stop period low.

// File: rtl/rxdf_pkg.sv
package rxdf_pkg;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_START,
    RS_DATA,
    RS_PAR,
    RS_STOP1,
    RS_STOP2,
    RS_HOLD
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
    logic       brk;
  } rx_char_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {STAGES{RESET_VAL}};
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
    end
  end

  assign dout = sync_q[STAGES-1];

endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import rxdf_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          line,
  input  logic [1:0]    len_sel,
  input  logic          par_en,
  input  logic          stop_sel,
  output logic [DW-1:0] shreg,
  output logic          par_bit,
  output logic          fe_now,
  output logic          brk_now,
  output logic          char_done
);

  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DW);
  localparam logic [CW-1:0] FULL_M1 = CW'(OVS - 1);
  localparam logic [CW-1:0] HALF_M1 = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] TQ_M1   = CW'((3 * OVS) / 4 - 1);

  rx_state_e       state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [IW-1:0]   bit_q, bit_d;
  logic [DW-1:0]   sh_q, sh_d;
  logic            par_q, par_d;
  logic            hi_q, hi_d;
  logic            anylo_q, anylo_d;
  logic            alllo_q, alllo_d;
  logic            done;
  logic [IW-1:0]   last_bit;
  logic [CW-1:0]   stop2_lim;
  logic            full;

  assign last_bit  = IW'(DW - 4) + IW'(len_sel);
  assign stop2_lim = (len_sel == 2'b00) ? TQ_M1 : FULL_M1;
  assign full      = (cnt_q == FULL_M1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    par_d   = par_q;
    hi_d    = hi_q;
    anylo_d = anylo_q;
    alllo_d = alllo_q;
    done    = 1'b0;
    if (tick) begin
      unique case (state_q)
        RS_IDLE: begin
          if (!line) begin
            state_d = RS_START;
            cnt_d   = '0;
          end
        end
        RS_START: begin
          if (cnt_q == HALF_M1) begin
            cnt_d = '0;
            if (line) begin
              state_d = RS_IDLE;
            end else begin
              state_d = RS_DATA;
              bit_d   = '0;
              hi_d    = 1'b0;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RS_DATA: begin
          if (full) begin
            cnt_d = '0;
            sh_d  = {line, sh_q[DW-1:1]};
            hi_d  = hi_q | line;
            if (bit_q == last_bit) begin
              state_d = par_en ? RS_PAR : RS_STOP1;
            end else begin
              bit_d = bit_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RS_PAR: begin
          if (full) begin
            cnt_d   = '0;
            par_d   = line;
            hi_d    = hi_q | line;
            state_d = RS_STOP1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RS_STOP1: begin
          if (full) begin
            cnt_d   = '0;
            anylo_d = !line;
            alllo_d = !line;
            if (stop_sel) begin
              state_d = RS_STOP2;
            end else begin
              done    = 1'b1;
              state_d = (!hi_q && !line) ? RS_HOLD : RS_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RS_STOP2: begin
          if (cnt_q == stop2_lim) begin
            cnt_d   = '0;
            anylo_d = anylo_q | !line;
            alllo_d = alllo_q & !line;
            done    = 1'b1;
            state_d = (!hi_q && alllo_q && !line) ? RS_HOLD : RS_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RS_HOLD: begin
          if (line) state_d = RS_IDLE;
        end
        default: state_d = RS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      hi_q    <= 1'b0;
      anylo_q <= 1'b0;
      alllo_q <= 1'b0;
    end else if (tick) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      par_q   <= par_d;
      hi_q    <= hi_d;
      anylo_q <= anylo_d;
      alllo_q <= alllo_d;
    end
  end

  assign shreg     = sh_q;
  assign par_bit   = par_q;
  assign fe_now    = anylo_d;
  assign brk_now   = !hi_q && alllo_d;
  assign char_done = done;

  // R5: while parked after a break, a low line keeps the receiver parked
  assert_hold_until_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_HOLD && !line) |=> (state_q == RS_HOLD));

  // R4: a frame never completes straight out of the start-bit check
  assert_start_to_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_START) |=> (state_q inside {RS_START, RS_DATA, RS_IDLE}));

endmodule

// File: rtl/rx_char_eval.sv
module rx_char_eval
  import rxdf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] shreg,
  input  logic          par_bit,
  input  logic [1:0]    len_sel,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          fe_now,
  input  logic          brk_now,
  output rx_char_t      char_out
);

  logic [1:0]    shamt;
  logic [DW-1:0] data;

  assign shamt = 2'd3 - len_sel;
  assign data  = shreg >> shamt;

  always_comb begin
    char_out      = '0;
    char_out.data = data;
    char_out.perr = par_en & ((^data) ^ par_bit ^ par_odd);
    char_out.ferr = fe_now;
    char_out.brk  = brk_now;
  end

endmodule

// File: rtl/serial_rx_deframer.sv
module serial_rx_deframer
  import rxdf_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_line,
  input  logic          sample_tick,
  input  logic [1:0]    len_sel,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          stop_sel,
  output logic          char_valid,
  output logic [DW-1:0] char_data,
  output logic          char_perr,
  output logic          char_ferr,
  output logic          char_brk
);

  logic          rst_meta_q, rst_sync_q;
  logic          line_s;
  logic [DW-1:0] shreg;
  logic          par_bit, fe_now, brk_now, char_done;
  rx_char_t      char_eval;
  rx_char_t      char_q;
  logic          valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  rx_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .din  (rx_line),
    .dout (line_s)
  );

  rx_frame_ctrl #(.OVS(OVS), .DW(DW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .tick     (sample_tick),
    .line     (line_s),
    .len_sel  (len_sel),
    .par_en   (par_en),
    .stop_sel (stop_sel),
    .shreg    (shreg),
    .par_bit  (par_bit),
    .fe_now   (fe_now),
    .brk_now  (brk_now),
    .char_done(char_done)
  );

  rx_char_eval #(.DW(DW)) u_eval (
    .shreg   (shreg),
    .par_bit (par_bit),
    .len_sel (len_sel),
    .par_en  (par_en),
    .par_odd (par_odd),
    .fe_now  (fe_now),
    .brk_now (brk_now),
    .char_out(char_eval)
  );

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      valid_q <= 1'b0;
      char_q  <= '0;
    end else begin
      valid_q <= char_done;
      if (char_done) char_q <= char_eval;
    end
  end

  assign char_valid = valid_q;
  assign char_data  = char_q.data;
  assign char_perr  = char_q.perr;
  assign char_ferr  = char_q.ferr;
  assign char_brk   = char_q.brk;

  // R6: strobe lasts one clock
  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    char_valid |=> !char_valid);

  // R1: bits above the selected length are zero
  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_sync_q)
    char_valid |-> ((char_data >> (4'(DW - 3) + 4'(len_sel))) == '0));

  // R5: a break always carries a framing error and zero data
  assert_break_shape_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (char_valid && char_brk) |-> (char_ferr && char_data == '0));

  // R2: no parity slot means no parity error
  assert_no_parity_err_R2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (char_valid && !par_en) |-> !char_perr);

  // R6: data and flags hold between strobes
  assert_hold_outputs_R6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!char_valid && $past(!char_valid)) |-> $stable(char_q));

endmodule

// File: tb/tb_serial_rx_deframer.sv
module tb_serial_rx_deframer;

  typedef struct packed {
    logic [1:0] len;
    logic       pen;
    logic       podd;
    logic       ssel;
    logic [7:0] dat;
    logic       flip;
    logic [1:0] slo;
    logic [7:0] edat;
    logic       epe;
    logic       efe;
    logic       ebrk;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [0:NV-1] = '{
    '{2'd3, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 2'b00, 8'hA5, 1'b0, 1'b0, 1'b0},
    '{2'd0, 1'b1, 1'b0, 1'b1, 8'hFF, 1'b0, 2'b00, 8'h1F, 1'b0, 1'b0, 1'b0},
    '{2'd1, 1'b1, 1'b1, 1'b1, 8'h2C, 1'b0, 2'b00, 8'h2C, 1'b0, 1'b0, 1'b0},
    '{2'd2, 1'b1, 1'b0, 1'b0, 8'h81, 1'b1, 2'b00, 8'h01, 1'b1, 1'b0, 1'b0},
    '{2'd3, 1'b1, 1'b1, 1'b1, 8'h3C, 1'b1, 2'b00, 8'h3C, 1'b1, 1'b0, 1'b0},
    '{2'd3, 1'b0, 1'b0, 1'b0, 8'h5A, 1'b0, 2'b01, 8'h5A, 1'b0, 1'b1, 1'b0},
    '{2'd0, 1'b0, 1'b0, 1'b1, 8'h0A, 1'b0, 2'b10, 8'h0A, 1'b0, 1'b1, 1'b0},
    '{2'd3, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 2'b00, 8'h00, 1'b0, 1'b0, 1'b0},
    '{2'd2, 1'b0, 1'b0, 1'b1, 8'h7F, 1'b0, 2'b00, 8'h7F, 1'b0, 1'b0, 1'b0},
    '{2'd1, 1'b0, 1'b0, 1'b1, 8'h15, 1'b0, 2'b10, 8'h15, 1'b0, 1'b1, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_line;
  logic       sample_tick;
  logic [1:0] len_sel;
  logic       par_en, par_odd, stop_sel;
  logic       char_valid;
  logic [7:0] char_data;
  logic       char_perr, char_ferr, char_brk;

  int          n_chk = 0;
  int          n_err = 0;
  int          n_valid = 0;
  int          n_double = 0;
  logic        prev_v = 1'b0;
  logic [10:0] cap [0:63];

  always #5 clk = ~clk;

  serial_rx_deframer dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .sample_tick(sample_tick),
    .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd), .stop_sel(stop_sel),
    .char_valid(char_valid), .char_data(char_data), .char_perr(char_perr),
    .char_ferr(char_ferr), .char_brk(char_brk)
  );

  initial begin
    sample_tick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      sample_tick = 1'b1;
      @(negedge clk);
      sample_tick = 1'b0;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (char_valid === 1'b1) begin
        if (n_valid < 64) cap[n_valid] = {char_data, char_perr, char_ferr, char_brk};
        n_valid++;
        if (prev_v === 1'b1) n_double++;
      end
      prev_v = char_valid;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rx_line = v;
    repeat (n) @(posedge sample_tick);
  endtask

  task automatic send(input logic [1:0] len, input logic pen, input logic podd,
                      input logic ssel, input logic [7:0] dat, input logic flip,
                      input logic [1:0] slo, input int gap);
    int   nb;
    logic p;
    nb = 5 + int'(len);
    p  = podd ^ flip;
    hold(1'b0, 16);
    for (int i = 0; i < nb; i++) begin
      hold(dat[i], 16);
      p = p ^ dat[i];
    end
    if (pen) hold(p, 16);
    hold(!slo[0], 16);
    if (ssel) hold(!slo[1], (len == 2'd0) ? 8 : 16);
    if (gap > 0) hold(1'b1, gap);
  endtask

  task automatic cfg(input logic [1:0] l, input logic pe, input logic po, input logic s);
    len_sel = l; par_en = pe; par_odd = po; stop_sel = s;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int   base;
    vec_t v;
    rx_line = 1'b1;
    cfg(2'd3, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8: reset state
    chk("R8 valid after reset", 32'(char_valid), 32'd0);
    chk("R8 data/flags after reset", 32'({char_data, char_perr, char_ferr, char_brk}), 32'd0);
    hold(1'b1, 32);

    // vector table: R1 lengths, R2 parity, R3 stop handling
    for (int i = 0; i < NV; i++) begin
      string req;
      v = VECS[i];
      req = (v.slo != 2'b00) ? "R3" : (v.pen ? "R2" : "R1");
      cfg(v.len, v.pen, v.podd, v.ssel);
      base = n_valid;
      send(v.len, v.pen, v.podd, v.ssel, v.dat, v.flip, v.slo, 32);
      chk({req, " char count"}, 32'(n_valid - base), 32'd1);
      chk({req, " char fields"}, 32'(cap[base]), 32'({v.edat, v.epe, v.efe, v.ebrk}));
    end

    // R4: short glitches are not characters
    cfg(2'd3, 1'b0, 1'b0, 1'b0);
    base = n_valid;
    hold(1'b0, 4);
    hold(1'b1, 32);
    hold(1'b0, 1);
    hold(1'b1, 32);
    chk("R4 glitch rejected", 32'(n_valid - base), 32'd0);
    send(2'd3, 1'b0, 1'b0, 1'b0, 8'h96, 1'b0, 2'b00, 32);
    chk("R4 frame after glitch", 32'(cap[base]), 32'({8'h96, 3'b000}));

    // R5: break, one report, parked until line high
    cfg(2'd3, 1'b1, 1'b0, 1'b0);
    base = n_valid;
    hold(1'b0, 16 * 14);
    chk("R5 single break report", 32'(n_valid - base), 32'd1);
    chk("R5 break fields", 32'(cap[base]), 32'({8'h00, 1'b0, 1'b1, 1'b1}));
    hold(1'b1, 32);
    send(2'd3, 1'b1, 1'b0, 1'b0, 8'h69, 1'b0, 2'b00, 32);
    chk("R5 frame after break", 32'(n_valid - base), 32'd2);
    chk("R5 frame after break fields", 32'(cap[base + 1]), 32'({8'h69, 3'b000}));

    // R7: back-to-back characters with no idle gap
    cfg(2'd3, 1'b0, 1'b0, 1'b0);
    base = n_valid;
    send(2'd3, 1'b0, 1'b0, 1'b0, 8'hC3, 1'b0, 2'b00, 0);
    send(2'd3, 1'b0, 1'b0, 1'b0, 8'h3E, 1'b0, 2'b00, 32);
    chk("R7 both chars seen", 32'(n_valid - base), 32'd2);
    chk("R7 first char", 32'(cap[base]), 32'({8'hC3, 3'b000}));
    chk("R7 second char", 32'(cap[base + 1]), 32'({8'h3E, 3'b000}));

    // R6: strobe width and hold between strobes
    chk("R6 no double-wide strobe", 32'(n_double), 32'd0);
    chk("R6 outputs held after last strobe",
        32'({char_data, char_perr, char_ferr, char_brk}), 32'({8'h3E, 3'b000}));

    finish_run();
  end

endmodule